// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives a slower clock for use off the chip from the reference clock. A programmable counter divides the reference clock by a factor N. N is assembled from three configuration bytes. Each time the counter reaches its terminal count it flips a toggle stage, so the output stays high for N reference cycles and low for N reference cycles. The duty cycle is therefore always 50%, and the full output period is 2N reference cycles.

An enable input gates the whole path. While it is low, the counter is held cleared and the output is held low. When it rises, the divider starts from a known phase: the first output edge is a rising edge, N cycles later. A divisor written while the divider runs is picked up only at the next terminal count. The half-period in progress therefore always finishes with the divisor it started with.

The control is a three-state machine:
- `ST_IDLE`: disabled, output low.
- `ST_LOW`: running, output low.
- `ST_HIGH`: running, output high.

The transitions are:
- start (`ST_IDLE`→`ST_LOW`, enable sampled high).
- rise (`ST_LOW`→`ST_HIGH`, terminal count).
- fall (`ST_HIGH`→`ST_LOW`, terminal count).
- stop (`ST_LOW` or `ST_HIGH`→`ST_IDLE`, enable sampled low). Stop takes priority over a terminal count in the same cycle.

Top module: `clkout_div`

## Requirements
- R1: The divisor is N = {cfg_hi[HI_W-1:0], cfg_mid, cfg_lo}, where HI_W = DIV_W - 2*BYTE_W. The bits of cfg_hi at HI_W and above are ignored.
- R2: A programmed divisor of 0 or 1 behaves exactly as N = 2.
- R3: While enabled, every high phase and every low phase of clk_out lasts exactly N reference cycles. The output toggles only at a terminal count.
- R4: With N = 2 the output period is 4 reference cycles, which is the fastest output.
- R5: With the largest divisor, 2^DIV_W - 1, the output period is 2*(2^DIV_W - 1) reference cycles, which is the slowest output.
- R6: When en is sampled low at a clock edge, clk_out is low after that edge. It stays low, and the counter stays cleared, for as long as en is low.
- R7: When en is sampled high at edge k while the divider is idle, the counter starts from zero and clk_out stays low. The first rising edge of clk_out comes at edge k+N.
- R8: A change of the configuration bytes while running does not alter the half-period in progress. The new N applies from the next terminal count onward.
- R9: rst_n low (asynchronous, active low) forces clk_out low and returns to `ST_IDLE`. After release, the divider starts as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | BYTE_W (8) | Divisor bits [BYTE_W-1:0] |
| cfg_mid | input | BYTE_W (8) | Divisor bits [2*BYTE_W-1:BYTE_W] |
| cfg_hi | input | BYTE_W (8) | Low HI_W bits are the top divisor bits; the remaining bits are ignored |
| en | input | 1 | Divider enable; output held low when 0 |
| clk_out | output | 1 | Divided clock, 50% duty cycle |

## Verification
The bench builds the block with BYTE_W = 4 and DIV_W = 10. This leaves the two top bits of cfg_hi as ignored bits and caps N at 1023. With that cap, the slowest setting (R5) is checked edge by edge within a few thousand cycles, instead of the two million cycles the default width would need. The same build still covers all three configuration bytes. It also covers the clamp of 0 and 1 to 2, a divisor change partway through a half-period, and a stop while the output is high.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Divider control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // disabled, output low
        ST_LOW  = 2'd1,   // running, output low phase
        ST_HIGH = 2'd2    // running, output high phase
    } cd_state_t;

    // Smallest divisor the counter accepts
    localparam int unsigned DIV_MIN = 2;

endpackage

// File: rtl/clkdiv_cfg.sv
// Assembles the divisor from three configuration bytes and clamps it.
module clkdiv_cfg #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 20
) (
    input  logic [BYTE_W-1:0] cfg_lo,
    input  logic [BYTE_W-1:0] cfg_mid,
    input  logic [BYTE_W-1:0] cfg_hi,
    output logic [DIV_W-1:0]  div_out
);
    import clkdiv_pkg::*;

    localparam int HI_W = DIV_W - 2*BYTE_W;

    logic [DIV_W-1:0] div_raw;

    // R1: top byte contributes only its low HI_W bits
    assign div_raw = {cfg_hi[HI_W-1:0], cfg_mid, cfg_lo};

    generate
        if (HI_W < BYTE_W) begin : g_hi_spare
            logic unused_hi_bits;
            assign unused_hi_bits = ^cfg_hi[BYTE_W-1:HI_W];
        end
    endgenerate

    // R2: values below the minimum are raised to it
    always_comb begin
        if (div_raw < DIV_W'(DIV_MIN))
            div_out = DIV_W'(DIV_MIN);
        else
            div_out = div_raw;
    end

endmodule

// File: rtl/clkdiv_counter.sv
// Divide-by-N counter with terminal-count pulse and divisor capture.
module clkdiv_counter #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tc
);
    import clkdiv_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;

    assign tc = run && en && (cnt == div_q - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= DIV_W'(DIV_MIN);
        end else if (!en) begin
            cnt   <= '0;
        end else if (!run || tc) begin
            // capture divisor at start and at each terminal count (R7, R8)
            cnt   <= '0;
            div_q <= div_in;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en) |-> (cnt < div_q));

    // R2
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_q >= DIV_W'(DIV_MIN)));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !tc) |=> $stable(div_q));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

endmodule

// File: rtl/clkdiv_fsm.sv
// Output state machine: idle / low phase / high phase.
module clkdiv_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tc,
    output logic run,
    output logic clk_out
);
    import clkdiv_pkg::*;

    cd_state_t state_q;
    cd_state_t state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = en ? ST_LOW : ST_IDLE;            // start
            ST_LOW:  if (!en)     state_nx = ST_IDLE;             // stop
                     else if (tc) state_nx = ST_HIGH;             // rise
            ST_HIGH: if (!en)     state_nx = ST_IDLE;             // stop
                     else if (tc) state_nx = ST_LOW;              // fall
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // output register, glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_out <= 1'b0;
        else        clk_out <= (state_nx == ST_HIGH);
    end

    assign run = (state_q != ST_IDLE);

    // R6
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_out);

    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && tc) |=> (clk_out != $past(clk_out)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !tc) |=> $stable(clk_out));

    // R7
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en) |=> (state_q == ST_LOW && !clk_out));

endmodule

// File: rtl/clkout_div.sv
// Programmable clock output divider, top level.
module clkout_div #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cfg_lo,
    input  logic [BYTE_W-1:0] cfg_mid,
    input  logic [BYTE_W-1:0] cfg_hi,
    input  logic              en,
    output logic              clk_out
);
    logic [DIV_W-1:0] div_val;
    logic             tc;
    logic             run;

    clkdiv_cfg #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_cfg (
        .cfg_lo  (cfg_lo),
        .cfg_mid (cfg_mid),
        .cfg_hi  (cfg_hi),
        .div_out (div_val)
    );

    clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .run    (run),
        .div_in (div_val),
        .tc     (tc)
    );

    clkdiv_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tc      (tc),
        .run     (run),
        .clk_out (clk_out)
    );

    // R9
    reset_low_chk: assert property (@(posedge clk) !rst_n |-> !clk_out);

endmodule

// File: tb/tb_clkout_div.sv
module tb_clkout_div;
    localparam int BYTE_W = 4;
    localparam int DIV_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BYTE_W-1:0] cfg_lo = '0, cfg_mid = '0, cfg_hi = '0;
    logic              en = 1'b0;
    logic              clk_out;

    clkout_div #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_mid(cfg_mid),
        .cfg_hi(cfg_hi), .en(en), .clk_out(clk_out)
    );

    always #5 clk = ~clk;

    int    cyc = 0;
    int    n_tests = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    bit    prev = 1'b0;
    bit    done = 1'b0;
    int    q_cyc[$];
    bit    q_lvl[$];
    string q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_edge(int at, bit lvl, string tag);
        q_cyc.push_back(at);
        q_lvl.push_back(lvl);
        q_tag.push_back(tag);
    endtask

    // monitor: pops one expected edge per observed output change
    always @(negedge clk) begin
        if (mon_on && rst_n && (clk_out !== prev)) begin
            if (q_cyc.size() == 0) begin
                check_eq("R3", "unexpected edge at cycle", cyc, -1);
            end else begin
                int    ec;
                bit    el;
                string et;
                ec = q_cyc.pop_front();
                el = q_lvl.pop_front();
                et = q_tag.pop_front();
                check_eq(et, "edge cycle", cyc, ec);
                check_eq(et, "edge level", int'(clk_out), int'(el));
            end
            prev = clk_out;
        end
    end

    task automatic wait_until(int target);
        while (cyc < target) @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(int hi, int mid, int lo);
        cfg_hi  = BYTE_W'(hi);
        cfg_mid = BYTE_W'(mid);
        cfg_lo  = BYTE_W'(lo);
    endtask

    // idle for one edge, then enable and expect `edges` toggles of period n
    task automatic run_seg(int hi, int mid, int lo, int n, int edges, string tag);
        int k;
        @(negedge clk); #1;
        en = 1'b0;
        @(negedge clk); #1;
        set_cfg(hi, mid, lo);
        en = 1'b1;
        k = cyc + 1;
        for (int i = 1; i <= edges; i++) push_edge(k + i*n, (i % 2) == 1, tag);
        wait_until(k + edges*n);
        check_eq(tag, "pending edges", q_cyc.size(), 0);
    endtask

    initial begin
        int k;
        int d;
        repeat (3) @(negedge clk);
        // R9 reset state
        check_eq("R9", "clk_out in reset", int'(clk_out), 0);
        #1 rst_n = 1'b1;
        prev = 1'b0;
        mon_on = 1'b1;
        // R6 disabled after reset
        repeat (5) @(negedge clk);
        #1 check_eq("R6", "clk_out while disabled", int'(clk_out), 0);

        run_seg(0, 0, 2, 2, 6, "R4");      // fastest: N=2
        run_seg(0, 0, 0, 2, 4, "R2");      // 0 behaves as 2
        run_seg(0, 0, 1, 2, 4, "R2");      // 1 behaves as 2
        run_seg(0, 0, 7, 7, 4, "R7");      // first rise N after start
        run_seg(0, 0, 5, 5, 6, "R3");
        // R1: hi=0101 -> only bits [1:0]=01 used, N = 0x111 = 273
        run_seg(5, 1, 1, 273, 2, "R1");

        // R8: N=5 then change to 3 two cycles into the first half-period
        @(negedge clk); #1; en = 1'b0;
        @(negedge clk); #1;
        set_cfg(0, 0, 5); en = 1'b1;
        k = cyc + 1;
        push_edge(k + 5, 1'b1, "R8");
        push_edge(k + 8, 1'b0, "R8");
        push_edge(k + 11, 1'b1, "R8");
        push_edge(k + 14, 1'b0, "R8");
        wait_until(k + 2);
        set_cfg(0, 0, 3);
        wait_until(k + 14);
        check_eq("R8", "pending edges", q_cyc.size(), 0);

        // R6: stop while high; N=4, three edges leaves output high
        @(negedge clk); #1; en = 1'b0;
        @(negedge clk); #1;
        set_cfg(0, 0, 4); en = 1'b1;
        k = cyc + 1;
        for (int i = 1; i <= 3; i++) push_edge(k + i*4, (i % 2) == 1, "R6");
        wait_until(k + 12);
        check_eq("R6", "clk_out high before stop", int'(clk_out), 1);
        en = 1'b0;
        d = cyc;
        push_edge(d + 1, 1'b0, "R6");
        wait_until(d + 12);
        check_eq("R6", "clk_out after stop", int'(clk_out), 0);
        check_eq("R6", "pending edges", q_cyc.size(), 0);

        // R5: slowest setting, N = 1023
        run_seg(3, 15, 15, 1023, 2, "R5");

        // R9: reset while running, then restart
        @(negedge clk); #1; en = 1'b0;
        @(negedge clk); #1;
        mon_on = 1'b0;
        set_cfg(0, 0, 3); en = 1'b1;
        wait_until(cyc + 4);          // output high at this point
        rst_n = 1'b0;
        #1 check_eq("R9", "clk_out during reset", int'(clk_out), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        prev = 1'b0;
        q_cyc.delete(); q_lvl.delete(); q_tag.delete();
        mon_on = 1'b1;
        k = cyc + 1;
        push_edge(k + 3, 1'b1, "R9");
        push_edge(k + 6, 1'b0, "R9");
        wait_until(k + 6);
        check_eq("R9", "pending edges", q_cyc.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule